// File: doc/BRIEF.md
# Indexed Vertex Fetch Sequencer with Post-Transform Cache

This block runs one draw at a time. A draw produces a stream of vertex numbers. For each one it finds the transformed result, either in a small cache or by asking an external shader unit, and it hands the number and the result to the next stage over a valid/ready stream. A one-cycle `done` pulse closes the draw.

There are two ways to form the vertex numbers. A sequential draw uses the loop counter plus a start offset, wrapping at 16 bits. Each of its vertices goes to the shader, and the cache is neither searched nor written. An indexed draw reads each vertex number from an index array in memory, which holds either byte entries or little-endian halfword entries. An indexed draw ignores the start offset. Its vertex numbers are compared against a 32-entry cache of recent results. On a hit the stored result goes out at once, with no shader request. On a miss the shader result is written into the cache, round robin, and then sent out.

Every draw start empties the cache. The value 0xFFFF is reserved as the restart marker. An indexed vertex number equal to it raises an error pulse, and that entry is skipped.

Top module: `vfc_top`

## Requirements
- R1: After reset, `outValid`, `memReq`, `xfReq`, `busy`, `done` and `idxErr` are all low.
- R2: A sequential draw of N vertices emits the numbers (offset + i) mod 65536 for i = 0..N-1, in order. Each of them is preceded by its own transform request, with no cache hit and no error, and this includes 0xFFFF.
- R3: An indexed draw reads entry i at `idxBase + i` in byte format (`idxWide`=0), using `memData[7:0]` zero-extended. In halfword format (`idxWide`=1) it reads at `idxBase + 2*i` and uses all of `memData[15:0]`. `drawOffset` has no effect on an indexed draw.
- R4: In an indexed draw, a vertex number equal to a stored tag is emitted with the stored result and without a transform request. The lowest-numbered matching entry wins.
- R5: An indexed miss raises `xfReq` with the vertex number. The result returned with `xfAck` is emitted and written into the entry at the replacement pointer, which then advances modulo 32.
- R6: Every accepted draw start invalidates all 32 entries and returns the replacement pointer to entry 0, so nothing from an earlier draw can hit.
- R7: An indexed vertex number of 0xFFFF produces a one-cycle `idxErr` pulse. That entry is neither transformed nor emitted, but it still counts toward N.
- R8: While `outValid` is high and `outReady` is low, `outValid`, `outVertex` and `outData` hold their values.
- R9: `done` pulses for exactly one cycle, in the cycle after the last entry is accepted on the output or skipped. A draw with N = 0 gives `done` one cycle after the start, with no other activity.
- R10: `drawStart` is ignored while `busy` is high.
- R11: `memReq` holds with a stable `memAddr` until `memAck`, and `xfReq` holds with a stable `xfVertex` until `xfAck`. At most one of `memReq`, `xfReq` and `outValid` is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| drawStart | input | 1 | Starts a draw when idle |
| drawIndexed | input | 1 | 1 = indexed draw, 0 = sequential draw |
| idxWide | input | 1 | Index entry size: 1 = halfword, 0 = byte |
| drawCount | input | CNT_W | Number of vertices N |
| drawOffset | input | 16 | Start offset for sequential draws |
| idxBase | input | ADDR_W | Byte address of the index array |
| memReq | output | 1 | Index read request |
| memAddr | output | ADDR_W | Byte address of the index entry |
| memAck | input | 1 | Read completes; `memData` is valid |
| memData | input | 16 | Little-endian halfword at `memAddr` |
| xfReq | output | 1 | Transform request |
| xfVertex | output | 16 | Vertex number to transform |
| xfAck | input | 1 | Transform completes; `xfResult` is valid |
| xfResult | input | DATA_W | Transformed vertex |
| outValid | output | 1 | Output vertex valid |
| outReady | input | 1 | Downstream accepts the vertex |
| outVertex | output | 16 | Emitted vertex number |
| outData | output | DATA_W | Emitted transformed result |
| busy | output | 1 | A draw is in progress |
| done | output | 1 | One-cycle end-of-draw pulse |
| idxErr | output | 1 | One-cycle pulse for a 0xFFFF index |

## Verification
The hardest state to reach from the ports is a full cache that has wrapped, where an early index was evicted but a later one is still resident. Reaching it takes more than 32 distinct misses in one draw, followed by a revisit of both kinds of index. The stimulus is a byte-format draw of 40 distinct indices that ends with two evicted values and two resident ones.

Each transform result carries a running serial number, so a hit shows up at the output as an older result. A repeated identical draw shows whether the cache was invalidated at the start. Random handshake delays on all three interfaces keep the request and output hold rules under pressure throughout.

// File: rtl/vfc_pkg.sv
package vfc_pkg;
  localparam int VTX_W = 16;
  localparam logic [VTX_W-1:0] VTX_RESTART = '1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEQ, ST_FETCH, ST_LOOK, ST_XF, ST_EMIT
  } vfcState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrAll;   // latch draw config, invalidate cache
    logic capSeq;   // vertex = counter + offset
    logic capIdx;   // vertex = index memory data
    logic takeHit;  // output data from matching entry
    logic takeXf;   // output data from shader, fill on indexed
    logic stepCnt;  // advance loop counter
  } vfcStrobe_t;
endpackage

// File: rtl/vfc_data.sv
module vfc_data
  import vfc_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 16,
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  vfcStrobe_t        stb,
  input  logic              drawIndexed,
  input  logic              idxWide,
  input  logic [CNT_W-1:0]  drawCount,
  input  logic [VTX_W-1:0]  drawOffset,
  input  logic [ADDR_W-1:0] idxBase,
  input  logic [15:0]       memData,
  input  logic [DATA_W-1:0] xfResult,
  output logic [ADDR_W-1:0] memAddr,
  output logic [VTX_W-1:0]  vnum,
  output logic [DATA_W-1:0] outData,
  output logic              hit,
  output logic              illegal,
  output logic              lastStep,
  output logic              indexed
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [CNT_W-1:0]  cntQ, countQ;
  logic [VTX_W-1:0]  offsetQ, vnumQ;
  logic [ADDR_W-1:0] baseQ;
  logic              wideQ, indexedQ;
  logic [DATA_W-1:0] outDataQ;
  logic [PTR_W-1:0]  ptrQ, hitSel;
  logic [VTX_W-1:0]  tagQ  [ENTRIES];
  logic [DATA_W-1:0] slotQ [ENTRIES];
  logic [ENTRIES-1:0] matchVec;

  // parallel tag compare
  for (genvar g = 0; g < ENTRIES; g++) begin : g_match
    assign matchVec[g] = (tagQ[g] == vnumQ);
  end

  // lowest matching entry wins
  always_comb begin
    hitSel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) hitSel = PTR_W'(i);
    end
  end

  assign hit      = |matchVec;
  assign illegal  = (vnumQ == VTX_RESTART);
  assign lastStep = (cntQ == countQ - CNT_W'(1));
  assign indexed  = indexedQ;
  assign vnum     = vnumQ;
  assign outData  = outDataQ;
  assign memAddr  = baseQ + (wideQ ? (ADDR_W'(cntQ) << 1) : ADDR_W'(cntQ));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ     <= '0;
      countQ   <= '0;
      offsetQ  <= '0;
      baseQ    <= '0;
      wideQ    <= 1'b0;
      indexedQ <= 1'b0;
      vnumQ    <= '0;
      outDataQ <= '0;
      ptrQ     <= '0;
      for (int i = 0; i < ENTRIES; i++) tagQ[i] <= '1;
    end else begin
      if (stb.clrAll) begin
        cntQ     <= '0;
        countQ   <= drawCount;
        offsetQ  <= drawOffset;
        baseQ    <= idxBase;
        wideQ    <= idxWide;
        indexedQ <= drawIndexed;
        ptrQ     <= '0;
        for (int i = 0; i < ENTRIES; i++) tagQ[i] <= '1;
      end
      if (stb.capSeq) vnumQ <= offsetQ + VTX_W'(cntQ);
      if (stb.capIdx) vnumQ <= wideQ ? memData : {8'h00, memData[7:0]};
      if (stb.takeHit) outDataQ <= slotQ[hitSel];
      if (stb.takeXf) begin
        outDataQ <= xfResult;
        if (indexedQ) begin
          tagQ[ptrQ] <= vnumQ;
          ptrQ <= (ptrQ == PTR_W'(ENTRIES - 1)) ? '0 : ptrQ + PTR_W'(1);
        end
      end
      if (stb.stepCnt) cntQ <= cntQ + CNT_W'(1);
    end
  end

  // result storage needs no reset: tags decide validity
  always_ff @(posedge clk) begin
    if (stb.takeXf && indexedQ) slotQ[ptrQ] <= xfResult;
  end
endmodule

// File: rtl/vfc_ctrl.sv
module vfc_ctrl
  import vfc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       drawStart,
  input  logic       drawIndexed,
  input  logic       countZero,
  input  logic       memAck,
  input  logic       xfAck,
  input  logic       outReady,
  input  logic       hit,
  input  logic       illegal,
  input  logic       lastStep,
  input  logic       indexed,
  output vfcStrobe_t stb,
  output logic       memReq,
  output logic       xfReq,
  output logic       outValid,
  output logic       busy,
  output logic       done,
  output logic       idxErr
);
  vfcState_t stQ, stD;
  logic doneSet, errSet, doneQ, errQ;

  always_comb begin
    stD     = stQ;
    stb     = '0;
    doneSet = 1'b0;
    errSet  = 1'b0;
    unique case (stQ)
      ST_IDLE: if (drawStart) begin
        stb.clrAll = 1'b1;
        if (countZero) doneSet = 1'b1;
        else stD = drawIndexed ? ST_FETCH : ST_SEQ;
      end
      ST_SEQ: begin
        stb.capSeq = 1'b1;
        stD = ST_XF;
      end
      ST_FETCH: if (memAck) begin
        stb.capIdx = 1'b1;
        stD = ST_LOOK;
      end
      ST_LOOK: begin
        if (illegal) begin
          errSet = 1'b1;
          if (lastStep) begin
            doneSet = 1'b1;
            stD = ST_IDLE;
          end else begin
            stb.stepCnt = 1'b1;
            stD = ST_FETCH;
          end
        end else if (hit) begin
          stb.takeHit = 1'b1;
          stD = ST_EMIT;
        end else begin
          stD = ST_XF;
        end
      end
      ST_XF: if (xfAck) begin
        stb.takeXf = 1'b1;
        stD = ST_EMIT;
      end
      ST_EMIT: if (outReady) begin
        if (lastStep) begin
          doneSet = 1'b1;
          stD = ST_IDLE;
        end else begin
          stb.stepCnt = 1'b1;
          stD = indexed ? ST_FETCH : ST_SEQ;
        end
      end
      default: stD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stQ   <= ST_IDLE;
      doneQ <= 1'b0;
      errQ  <= 1'b0;
    end else begin
      stQ   <= stD;
      doneQ <= doneSet;
      errQ  <= errSet;
    end
  end

  assign memReq   = (stQ == ST_FETCH);
  assign xfReq    = (stQ == ST_XF);
  assign outValid = (stQ == ST_EMIT);
  assign busy     = (stQ != ST_IDLE);
  assign done     = doneQ;
  assign idxErr   = errQ;
endmodule

// File: rtl/vfc_top.sv
module vfc_top
  import vfc_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 16,
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              drawStart,
  input  logic              drawIndexed,
  input  logic              idxWide,
  input  logic [CNT_W-1:0]  drawCount,
  input  logic [15:0]       drawOffset,
  input  logic [ADDR_W-1:0] idxBase,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memAck,
  input  logic [15:0]       memData,
  output logic              xfReq,
  output logic [15:0]       xfVertex,
  input  logic              xfAck,
  input  logic [DATA_W-1:0] xfResult,
  output logic              outValid,
  input  logic              outReady,
  output logic [15:0]       outVertex,
  output logic [DATA_W-1:0] outData,
  output logic              busy,
  output logic              done,
  output logic              idxErr
);
  vfcStrobe_t stb;
  logic hit, illegal, lastStep, indexed;
  logic [VTX_W-1:0] vnum;

  vfc_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .drawStart(drawStart), .drawIndexed(drawIndexed),
    .countZero(drawCount == '0), .memAck(memAck), .xfAck(xfAck),
    .outReady(outReady), .hit(hit), .illegal(illegal), .lastStep(lastStep),
    .indexed(indexed), .stb(stb), .memReq(memReq), .xfReq(xfReq),
    .outValid(outValid), .busy(busy), .done(done), .idxErr(idxErr)
  );

  vfc_data #(.DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) i_data (
    .clk(clk), .rstN(rstN), .stb(stb), .drawIndexed(drawIndexed),
    .idxWide(idxWide), .drawCount(drawCount), .drawOffset(drawOffset),
    .idxBase(idxBase), .memData(memData), .xfResult(xfResult),
    .memAddr(memAddr), .vnum(vnum), .outData(outData), .hit(hit),
    .illegal(illegal), .lastStep(lastStep), .indexed(indexed)
  );

  assign xfVertex  = vnum;
  assign outVertex = vnum;
endmodule

// File: rtl/vfc_checker.sv
module vfc_checker #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr,
  input logic              xfReq,
  input logic              xfAck,
  input logic [15:0]       xfVertex,
  input logic              outValid,
  input logic              outReady,
  input logic [15:0]       outVertex,
  input logic [DATA_W-1:0] outData,
  input logic              busy,
  input logic              done,
  input logic              idxErr
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq && !xfReq && !outValid); // R1
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outVertex) && $stable(outData)); // R8
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr)); // R11
  AST_XF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    xfReq && !xfAck |=> xfReq && $stable(xfVertex)); // R11
  AST_ONE_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    $countones({memReq, xfReq, outValid}) <= 1); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R9
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    idxErr |=> !idxErr); // R7
  AST_ERR_NO_EMIT: assert property (@(posedge clk) disable iff (!rstN)
    idxErr |-> !outValid && !xfReq); // R7
endmodule

bind vfc_top vfc_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memAck(memAck), .memAddr(memAddr),
  .xfReq(xfReq), .xfAck(xfAck), .xfVertex(xfVertex), .outValid(outValid),
  .outReady(outReady), .outVertex(outVertex), .outData(outData), .busy(busy),
  .done(done), .idxErr(idxErr)
);

// File: tb/test_vfc_top.sv
module test_vfc_top;
  localparam int DATA_W = 32, CNT_W = 16, ADDR_W = 32;

  logic clk = 1'b0, rstN = 1'b0;
  logic drawStart = 0, drawIndexed = 0, idxWide = 0;
  logic [CNT_W-1:0] drawCount = '0;
  logic [15:0] drawOffset = '0;
  logic [ADDR_W-1:0] idxBase = '0;
  logic memReq, memAck = 0, xfReq, xfAck = 0, outValid, outReady = 0;
  logic [ADDR_W-1:0] memAddr;
  logic [15:0] memData, xfVertex, outVertex;
  logic [DATA_W-1:0] xfResult = '0, outData;
  logic busy, done, idxErr;

  always #4 clk = ~clk;

  vfc_top i_vfc_top (.*);

  logic [7:0] mem [256];
  assign memData = {mem[8'(memAddr + 1)], mem[8'(memAddr)]};

  int nChk = 0, nBad = 0, cyc = 0;
  int xfSerial = 0, seenDone = 0, seenErr = 0, expErr = 0;
  int expXf[$];
  logic [15:0] expOV[$];
  logic [31:0] expOD[$];
  string curTag = "R1";
  bit stall = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit prevMemWait = 0, prevXfWait = 0, prevOutWait = 0;
  logic [ADDR_W-1:0] pAddr;
  logic [15:0] pXv, pOv;
  logic [31:0] pOd;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // per-clock monitor and responder, away from the active edge
  always @(negedge clk) begin
    if (!rstN) begin
      memAck = 0; xfAck = 0; outReady = 0;
      prevMemWait = 0; prevXfWait = 0; prevOutWait = 0;
    end else begin
      if (prevMemWait) chk(memReq && memAddr == pAddr, "R11", "mem request hold", memAddr, pAddr);
      if (prevXfWait)  chk(xfReq && xfVertex == pXv, "R11", "transform request hold", xfVertex, pXv);
      if (prevOutWait) chk(outValid && outVertex == pOv && outData == pOd, "R8", "output hold", outData, pOd);
      if (done) seenDone++;
      if (idxErr) seenErr++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      memAck = memReq && (lfsr[0] | lfsr[1]);
      xfAck = xfReq && (lfsr[2] | lfsr[6]);
      outReady = stall ? (lfsr[3] & lfsr[4]) : (lfsr[3] | lfsr[5]);
      if (xfReq && xfAck) begin
        if (expXf.size() == 0) chk(0, curTag, "unexpected transform request", xfVertex, 0);
        else chk(xfVertex == 16'(expXf.pop_front()), curTag, "transform vertex", xfVertex, xfVertex);
        xfResult = {xfSerial[15:0], xfVertex};
        xfSerial++;
      end
      if (outValid && outReady) begin
        if (expOV.size() == 0) chk(0, curTag, "unexpected output", outVertex, 0);
        else begin
          logic [15:0] ev;
          logic [31:0] ed;
          ev = expOV.pop_front();
          ed = expOD.pop_front();
          chk(outVertex == ev, curTag, "output vertex", outVertex, ev);
          chk(outData == ed, curTag, "output data", outData, ed);
        end
      end
      prevMemWait = memReq && !memAck; pAddr = memAddr;
      prevXfWait  = xfReq && !xfAck;   pXv = xfVertex;
      prevOutWait = outValid && !outReady; pOv = outVertex; pOd = outData;
    end
  end

  // behavioural reference: fills the expected queues for one draw
  task automatic modelDraw(bit ix, bit wd, int base, int offs, int n);
    int tags[32];
    logic [31:0] dat[32];
    int ptr = 0;
    int s = xfSerial;
    for (int k = 0; k < 32; k++) tags[k] = -1;
    expErr = 0;
    for (int i = 0; i < n; i++) begin
      int v, hitAt;
      if (!ix) begin
        v = (offs + i) & 16'hFFFF;
        expXf.push_back(v); expOV.push_back(16'(v)); expOD.push_back({s[15:0], 16'(v)}); s++;
      end else begin
        if (wd) v = mem[(base + 2*i) & 255] | (mem[(base + 2*i + 1) & 255] << 8);
        else    v = mem[(base + i) & 255];
        if (v == 16'hFFFF) begin expErr++; continue; end
        hitAt = -1;
        for (int k = 31; k >= 0; k--) if (tags[k] == v) hitAt = k;
        if (hitAt >= 0) begin
          expOV.push_back(16'(v)); expOD.push_back(dat[hitAt]);
        end else begin
          expXf.push_back(v);
          tags[ptr] = v; dat[ptr] = {s[15:0], 16'(v)}; s++;
          ptr = (ptr + 1) % 32;
          expOV.push_back(16'(v)); expOD.push_back(dat[(ptr + 31) % 32]);
        end
      end
    end
  endtask

  task automatic runDraw(string tag, bit ix, bit wd, int base, int offs, int n, bit poke);
    int d0, k;
    curTag = tag;
    modelDraw(ix, wd, base, offs, n);
    seenErr = 0;
    d0 = seenDone;
    @(negedge clk);
    drawIndexed = ix; idxWide = wd; idxBase = ADDR_W'(base);
    drawOffset = 16'(offs); drawCount = CNT_W'(n); drawStart = 1;
    @(negedge clk);
    drawStart = 0;
    k = 0;
    while (seenDone == d0 && k < 20000) begin
      @(negedge clk);
      k++;
      if (poke && k == 3) begin
        chk(busy == 1'b1, "R10", "busy during draw", busy, 1);
        drawIndexed = 1; idxWide = 1; drawCount = 3; drawStart = 1;
      end
      if (poke && k == 4) drawStart = 0;
    end
    chk(k < 20000, tag, "draw finished", k, 0);
    repeat (3) @(negedge clk);
    chk(seenDone == d0 + 1, "R9", "single done pulse", seenDone - d0, 1);
    chk(expXf.size() == 0, tag, "transforms left over", expXf.size(), 0);
    chk(expOV.size() == 0, tag, "outputs left over", expOV.size(), 0);
    chk(seenErr == expErr, "R7", "error pulses", seenErr, expErr);
    chk(!busy, tag, "idle after draw", busy, 0);
    expXf.delete(); expOV.delete(); expOD.delete();
  endtask

  task automatic putHalf(int a, int v);
    mem[a & 255] = 8'(v);
    mem[(a + 1) & 255] = 8'(v >> 8);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    repeat (5) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(!outValid && !memReq && !xfReq && !busy && !done && !idxErr, "R1", "reset state",
        {outValid, memReq, xfReq, busy, done, idxErr}, 0);

    // R2 sequential draw, offset applied
    runDraw("R2", 0, 0, 0, 100, 5, 0);
    // R2 sequential wrap through 0xFFFF: no error, all transformed
    runDraw("R2", 0, 0, 0, 16'hFFFE, 4, 0);

    // R3/R4 byte entries with repeats
    mem[10] = 3; mem[11] = 7; mem[12] = 3; mem[13] = 3; mem[14] = 9; mem[15] = 7;
    runDraw("R4", 1, 0, 10, 999, 6, 0);

    // R3 halfword entries, offset ignored
    putHalf(100, 16'h0300); putHalf(102, 16'h0123); putHalf(104, 16'h0300); putHalf(106, 16'h00AB);
    runDraw("R3", 1, 1, 100, 500, 4, 0);

    // R5 eviction: 40 distinct then two evicted and two resident
    for (int i = 0; i < 40; i++) mem[i] = 8'(10 + i);
    mem[40] = 10; mem[41] = 11; mem[42] = 49; mem[43] = 45;
    runDraw("R5", 1, 0, 0, 0, 44, 0);

    // R6 identical draw again: cache must start empty
    mem[10] = 3; mem[11] = 7; mem[12] = 3; mem[13] = 3; mem[14] = 9; mem[15] = 7;
    runDraw("R6", 1, 0, 10, 0, 6, 0);
    runDraw("R6", 1, 0, 10, 0, 6, 0);

    // R7 restart marker, including as last entry
    putHalf(200, 5); putHalf(202, 16'hFFFF); putHalf(204, 5); putHalf(206, 16'h1234); putHalf(208, 16'hFFFF);
    runDraw("R7", 1, 1, 200, 0, 5, 0);

    // R8 heavy back-pressure
    stall = 1;
    runDraw("R8", 1, 0, 10, 0, 6, 0);
    runDraw("R8", 0, 0, 0, 40, 6, 0);
    stall = 0;

    // R9 empty draw
    runDraw("R9", 1, 0, 0, 0, 0, 0);

    // R10 start during busy has no effect
    runDraw("R10", 0, 0, 0, 7, 6, 1);

    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nBad++;
      nChk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end
endmodule